// File: doc/BRIEF.md
# Threshold-Gated Interrupt Bid Arbiter

This block gathers interrupt requests from eighteen sources that belong to a two-channel serial controller. The sources are the receivers, the transmitters, the receive watchdogs, break changes, loopback errors, flow-control character hits, address character hits, two input-pin change detectors and two counter/timers. It turns each request into a 12-bit bid. A receiver or transmitter bid carries its FIFO occupancy: filled slots for a receiver and empty slots for a transmitter. An event bid carries a priority field set by software. Either kind also carries a type code and a channel bit.

The block selects the largest bid that is both active and enabled. It asserts an active-low request line only when that bid, with its channel bit left out, is strictly greater than a programmable threshold. A host acknowledge strobe or an update strobe copies the current winner into a current-interrupt register, which the host decodes to find the service it needs. That register loads zero when nothing is above the threshold. Polling software can therefore set the threshold to zero, pulse update, and read the register.

Top module: `irq_bid_arbiter`

## Requirements
- R1: After reset `irq_n` is 1, `cir` is 0x000 and `status_view` is all zeros.
- R2: Receiver bids are {filled count[7:0], type, channel}, and transmitter bids are {empty count[7:0], 3'b010, channel}. The receiver type is 3'b001, or 3'b101 when `rx_err` of that channel is 1. Source index: 0 is receiver A, 1 is receiver B, 2 is transmitter A, 3 is transmitter B.
- R3: Event source e (0..13) has status/mask index 4+e and channel bit e%2. Sources 0 and 1 are the watchdogs, bidding {filled count, 3'b100, ch}. Every other source bids {prio[e-2][6:0], code[3:0], ch}, with these codes: e=2,3 break 1110; e=4,5 loopback error 1111; e=6,7 flow character 0111; e=8,9 address 1011; e=10,11 pin change 0110; e=12,13 counter 1000.
- R4: `rx_lvl` and `tx_lvl` select when a FIFO source bids, with the count compared against FIFO_DEPTH (64). The codes are 0: count ≥ 1, 1: count ≥ 32, 2: count ≥ 48, 3: count ≥ 64.
- R5: A source whose mask bit is 0 never drives `irq_n` low and never appears in `cir`.
- R6: `irq_n` is 0 only when the winning bid's bits 11:1 are strictly greater than `thresh[10:0]`. The channel bit takes no part in this test.
- R7: The largest enabled, active 12-bit bid wins. Among bids that are otherwise equal, channel B (bit 0 = 1) beats channel A.
- R8: One arbitration takes two clocks: inputs are sampled on one edge and the result is produced on the next. After an input changes, `irq_n` does not change at the next clock edge.
- R9: `ack_stb` or `upd_stb` loads `cir` with the winning bid, or with 0x000 if no bid is above the threshold. `cir` holds its value at all other times.
- R10: An event status bit is set by its `evt_in` pulse and cleared by a `stat_clr` write-one. When both arrive in the same cycle, the set wins. Event sources bid only while their status bit is set.
- R11: `status_view` shows bits 3:0 as the FIFO sources' bidding conditions and bits 17:4 as the event status bits. It shows the raw value when `masked_view` is 0, and the value ANDed with `mask` when `masked_view` is 1.
- R12: With `thresh` at zero, any single active and enabled source drives `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_fill | input | 2x8 | Filled receive FIFO slots per channel |
| rx_err | input | 2 | Receiver holds a character with an error, per channel |
| rx_lvl | input | 2x2 | Receiver start-bidding level per channel |
| tx_free | input | 2x8 | Empty transmit FIFO slots per channel |
| tx_lvl | input | 2x2 | Transmitter start-bidding level per channel |
| evt_in | input | 14 | Event pulses, one per event source |
| stat_clr | input | 14 | Write-one-to-clear strobes for event status |
| prio | input | 12x7 | Programmed priority fields for event sources 2..13 |
| mask | input | 18 | Per-source enable |
| thresh | input | 11 | Interrupt threshold, compared with bid bits 11:1 |
| masked_view | input | 1 | Selects masked status view |
| ack_stb | input | 1 | Interrupt acknowledge strobe |
| upd_stb | input | 1 | Update-current-interrupt command strobe |
| irq_n | output | 1 | Active-low interrupt request |
| cir | output | 12 | Captured current-interrupt value |
| status_view | output | 18 | Raw or masked source status |

## Verification
Two pairs of events can land in the same cycle. The first is an event pulse and a host write-one-to-clear on the same status bit. The bench drives both in one cycle, from a cleared bit and then from a set bit, and expects the bit to read as set in `status_view` afterwards. The second is a capture strobe arriving while the arbiter is still working through a changed set of bids. The bench changes a bid, checks that `irq_n` has not moved one clock later, and then judges each capture only after a full arbitration has settled. The bound properties require that `cir` loads zero whenever a strobe arrives with `irq_n` high.

// File: rtl/iarb_pkg.sv
package iarb_pkg;
  localparam int BID_W  = 12;
  localparam int CNT_W  = 8;
  localparam int PRIO_W = 7;
  localparam int THR_W  = 11;
  localparam int NCH    = 2;
  localparam int NFIFO  = 2 * NCH;
  localparam int NEVT   = 14;
  localparam int NSRC   = NFIFO + NEVT;
  localparam int NPRIO  = NEVT - 2;

  typedef logic [BID_W-1:0] bid_t;
  typedef logic [NSRC-1:0][BID_W-1:0] bid_vec_t;

  localparam logic [2:0] TY_RX_OK  = 3'b001;
  localparam logic [2:0] TY_RX_ERR = 3'b101;
  localparam logic [2:0] TY_WDOG   = 3'b100;
  localparam logic [2:0] TY_TX     = 3'b010;

  // bid layout for FIFO-backed sources: occupancy, 3-bit type, channel
  function automatic bid_t fifo_bid(input logic [CNT_W-1:0] cnt,
                                    input logic [2:0] ty, input logic ch);
    return {cnt, ty, ch};
  endfunction

  // bid layout for event sources: programmed field, 4-bit type, channel
  function automatic bid_t evt_bid(input logic [PRIO_W-1:0] p,
                                   input logic [3:0] ty, input logic ch);
    return {p, ty, ch};
  endfunction

  // type code per event kind (kind = event index / 2)
  function automatic logic [3:0] evt_type(input int kind);
    case (kind)
      1:       return 4'b1110;  // break change
      2:       return 4'b1111;  // loopback error
      3:       return 4'b0111;  // flow character
      4:       return 4'b1011;  // address character
      5:       return 4'b0110;  // pin change
      6:       return 4'b1000;  // counter
      default: return 4'b0000;
    endcase
  endfunction

  // start-bidding level test on an occupancy count
  function automatic logic level_met(input logic [CNT_W-1:0] cnt,
                                     input logic [1:0] sel, input int depth);
    int c;
    c = int'(cnt);
    case (sel)
      2'd0:    return c != 0;
      2'd1:    return c >= depth / 2;
      2'd2:    return c >= (depth * 3) / 4;
      default: return c >= depth;
    endcase
  endfunction

  function automatic bid_t pick_max(input bid_vec_t b);
    bid_t m;
    m = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (b[i] > m) m = b[i];
    end
    return m;
  endfunction

  // threshold test ignores the channel bit
  function automatic logic above(input bid_t b, input logic [THR_W-1:0] t);
    return b[BID_W-1:1] > t;
  endfunction
endpackage

// File: rtl/iarb_status.sv
module iarb_status #(
  parameter int N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_in,
  input  logic [N-1:0] clr_in,
  output logic [N-1:0] st_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          st_q[i] <= 1'b0;
      else if (set_in[i])  st_q[i] <= 1'b1;   // set beats clear
      else if (clr_in[i])  st_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/iarb_bidgen.sv
module iarb_bidgen
  import iarb_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic [NCH-1:0][CNT_W-1:0]    rx_fill,
  input  logic [NCH-1:0]               rx_err,
  input  logic [NCH-1:0][1:0]          rx_lvl,
  input  logic [NCH-1:0][CNT_W-1:0]    tx_free,
  input  logic [NCH-1:0][1:0]          tx_lvl,
  input  logic [NEVT-1:0]              st,
  input  logic [NPRIO-1:0][PRIO_W-1:0] prio,
  input  logic [NSRC-1:0]              mask,
  output logic [NFIFO-1:0]             fifo_ready,
  output logic [NSRC-1:0]              src_active,
  output bid_vec_t                     bid_eff
);
  bid_vec_t bid_raw;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign fifo_ready[c]       = level_met(rx_fill[c], rx_lvl[c], DEPTH);
    assign fifo_ready[NCH + c] = level_met(tx_free[c], tx_lvl[c], DEPTH);
    assign bid_raw[c]          = fifo_bid(rx_fill[c], rx_err[c] ? TY_RX_ERR : TY_RX_OK, 1'(c));
    assign bid_raw[NCH + c]    = fifo_bid(tx_free[c], TY_TX, 1'(c));
  end

  for (genvar e = 0; e < NEVT; e++) begin : g_evt
    localparam int CH = e % 2;
    if (e < 2) begin : g_wdog
      assign bid_raw[NFIFO + e] = fifo_bid(rx_fill[CH], TY_WDOG, 1'(CH));
    end else begin : g_prog
      assign bid_raw[NFIFO + e] = evt_bid(prio[e - 2], evt_type(e / 2), 1'(CH));
    end
  end

  assign src_active = {st, fifo_ready};

  for (genvar s = 0; s < NSRC; s++) begin : g_gate
    assign bid_eff[s] = (src_active[s] && mask[s]) ? bid_raw[s] : '0;
  end
endmodule

// File: rtl/iarb_arbiter.sv
module iarb_arbiter
  import iarb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  bid_vec_t         bid_in,
  input  logic [THR_W-1:0] thr,
  output bid_t             win_q,
  output logic             hot_q,
  output logic             eval_now
);
  logic     phase_q;
  bid_vec_t snap_q;
  bid_t     best;

  assign eval_now = phase_q;
  assign best     = pick_max(snap_q);

  // phase 0: sample bids; phase 1: publish winner and threshold result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      snap_q  <= '0;
      win_q   <= '0;
      hot_q   <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      if (!phase_q) begin
        snap_q <= bid_in;
      end else begin
        win_q <= best;
        hot_q <= above(best, thr);
      end
    end
  end
endmodule

// File: rtl/irq_bid_arbiter.sv
module irq_bid_arbiter
  import iarb_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NCH-1:0][CNT_W-1:0]     rx_fill,
  input  logic [NCH-1:0]                rx_err,
  input  logic [NCH-1:0][1:0]           rx_lvl,
  input  logic [NCH-1:0][CNT_W-1:0]     tx_free,
  input  logic [NCH-1:0][1:0]           tx_lvl,
  input  logic [NEVT-1:0]               evt_in,
  input  logic [NEVT-1:0]               stat_clr,
  input  logic [NPRIO-1:0][PRIO_W-1:0]  prio,
  input  logic [NSRC-1:0]               mask,
  input  logic [THR_W-1:0]              thresh,
  input  logic                          masked_view,
  input  logic                          ack_stb,
  input  logic                          upd_stb,
  output logic                          irq_n,
  output logic [BID_W-1:0]              cir,
  output logic [NSRC-1:0]               status_view
);
  logic [NEVT-1:0]  st_q;
  logic [NFIFO-1:0] fifo_ready;
  logic [NSRC-1:0]  src_active;
  bid_vec_t         bid_eff;
  bid_t             win_bid;
  logic             hot;
  logic             eval_now;
  logic             capture;
  bid_t             cir_q;

  iarb_status #(.N(NEVT)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_in (evt_in),
    .clr_in (stat_clr),
    .st_q   (st_q)
  );

  iarb_bidgen #(.DEPTH(FIFO_DEPTH)) u_bidgen (
    .rx_fill    (rx_fill),
    .rx_err     (rx_err),
    .rx_lvl     (rx_lvl),
    .tx_free    (tx_free),
    .tx_lvl     (tx_lvl),
    .st         (st_q),
    .prio       (prio),
    .mask       (mask),
    .fifo_ready (fifo_ready),
    .src_active (src_active),
    .bid_eff    (bid_eff)
  );

  iarb_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .bid_in   (bid_eff),
    .thr      (thresh),
    .win_q    (win_bid),
    .hot_q    (hot),
    .eval_now (eval_now)
  );

  assign capture = ack_stb | upd_stb;

  always_ff @(posedge clk) begin
    if (!rst_n)       cir_q <= '0;
    else if (capture) cir_q <= hot ? win_bid : '0;
  end

  assign cir         = cir_q;
  assign irq_n       = ~hot;
  assign status_view = masked_view ? (src_active & mask) : src_active;
endmodule

// File: rtl/irq_bid_arbiter_chk.sv
module irq_bid_arbiter_chk
  import iarb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ack_stb,
  input logic             upd_stb,
  input logic [BID_W-1:0] cir,
  input logic             irq_n,
  input logic             eval_now,
  input logic [BID_W-1:0] win_bid,
  input logic [NEVT-1:0]  evt_in,
  input logic [NEVT-1:0]  stat_clr,
  input logic [NEVT-1:0]  st_q
);
  // R8: result only moves on the evaluation half of the cycle
  assert_two_clock_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_now |=> ($stable(irq_n) && $stable(win_bid)));

  // R9: cir is untouched without a strobe
  assert_cir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_stb || upd_stb) |=> $stable(cir));

  // R9: strobe while nothing is above threshold loads zero
  assert_zero_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_stb || upd_stb) && irq_n) |=> (cir == '0));

  // R6: a raised request always captures a non-zero winner
  assert_live_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_stb || upd_stb) && !irq_n) |=> (cir != '0));

  // R12: a request is never raised with an empty winner
  assert_irq_has_winner_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (win_bid != '0));

  for (genvar e = 0; e < NEVT; e++) begin : g_st
    // R10: set wins over a simultaneous clear
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      evt_in[e] |=> st_q[e]);
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr[e] && !evt_in[e]) |=> !st_q[e]);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_clr[e] && !evt_in[e]) |=> $stable(st_q[e]));
  end
endmodule

bind irq_bid_arbiter irq_bid_arbiter_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack_stb  (ack_stb),
  .upd_stb  (upd_stb),
  .cir      (cir),
  .irq_n    (irq_n),
  .eval_now (eval_now),
  .win_bid  (win_bid),
  .evt_in   (evt_in),
  .stat_clr (stat_clr),
  .st_q     (st_q)
);

// File: tb/irq_bid_arbiter_test.sv
module irq_bid_arbiter_test;
  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [1:0][7:0]      rx_fill;
  logic [1:0]           rx_err;
  logic [1:0][1:0]      rx_lvl;
  logic [1:0][7:0]      tx_free;
  logic [1:0][1:0]      tx_lvl;
  logic [13:0]          evt_in;
  logic [13:0]          stat_clr;
  logic [11:0][6:0]     prio;
  logic [17:0]          mask;
  logic [10:0]          thresh;
  logic                 masked_view;
  logic                 ack_stb;
  logic                 upd_stb;
  logic                 irq_n;
  logic [11:0]          cir;
  logic [17:0]          status_view;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_bid_arbiter uut (
    .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .rx_err(rx_err), .rx_lvl(rx_lvl),
    .tx_free(tx_free), .tx_lvl(tx_lvl), .evt_in(evt_in), .stat_clr(stat_clr),
    .prio(prio), .mask(mask), .thresh(thresh), .masked_view(masked_view),
    .ack_stb(ack_stb), .upd_stb(upd_stb), .irq_n(irq_n), .cir(cir),
    .status_view(status_view)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_upd();
    upd_stb = 1'b1;
    @(negedge clk);
    upd_stb = 1'b0;
  endtask

  task automatic do_ack();
    ack_stb = 1'b1;
    @(negedge clk);
    ack_stb = 1'b0;
  endtask

  task automatic pulse_evt(input int i);
    evt_in[i] = 1'b1;
    @(negedge clk);
    evt_in[i] = 1'b0;
  endtask

  task automatic clear_inputs();
    rx_fill = '0; rx_err = '0; rx_lvl = '0; tx_free = '0; tx_lvl = '0;
    evt_in = '0; prio = '0; mask = '0; thresh = '0; masked_view = 1'b0;
    ack_stb = 1'b0; upd_stb = 1'b0;
    stat_clr = '1;
    @(negedge clk);
    stat_clr = '0;
    settle();
  endtask

  task automatic t_reset();
    chk("R1", "irq_n after reset", 32'(irq_n), 32'h1);
    chk("R1", "cir after reset", 32'(cir), 32'h0);
    chk("R1", "status after reset", 32'(status_view), 32'h0);
  endtask

  task automatic t_rx_basic();
    clear_inputs();
    mask = 18'h1; rx_fill[0] = 8'd5;
    @(negedge clk);
    chk("R8", "irq_n one clock after bid change", 32'(irq_n), 32'h1);
    settle();
    chk("R12", "irq_n with zero threshold", 32'(irq_n), 32'h0);
    do_upd();
    chk("R2", "receiver A bid", 32'(cir), 32'h052);
    chk("R11", "raw view of receiver A", 32'(status_view), 32'h1);
  endtask

  task automatic t_mask();
    clear_inputs();
    rx_fill[0] = 8'd5; mask = 18'h2;
    settle();
    chk("R5", "masked receiver keeps irq_n high", 32'(irq_n), 32'h1);
    do_ack();
    chk("R5", "masked receiver not captured", 32'(cir), 32'h0);
  endtask

  task automatic t_levels();
    clear_inputs();
    mask = 18'h1; rx_lvl[0] = 2'd1; rx_fill[0] = 8'd31;
    settle();
    chk("R4", "rx half level below", 32'(irq_n), 32'h1);
    rx_fill[0] = 8'd32;
    settle();
    do_upd();
    chk("R4", "rx half level reached", 32'(cir), 32'h202);
    rx_lvl[0] = 2'd3; rx_fill[0] = 8'd63;
    settle();
    chk("R4", "rx full level below", 32'(irq_n), 32'h1);
    rx_fill[0] = 8'd64;
    settle();
    do_upd();
    chk("R4", "rx full level reached", 32'(cir), 32'h402);
    rx_fill[0] = 8'd0; mask = 18'h8; tx_lvl[1] = 2'd2; tx_free[1] = 8'd47;
    settle();
    chk("R4", "tx three-quarter empty below", 32'(irq_n), 32'h1);
    tx_free[1] = 8'd48;
    settle();
    do_upd();
    chk("R2", "transmitter B bid", 32'(cir), 32'h305);
  endtask

  task automatic t_rx_error();
    clear_inputs();
    mask = 18'h1; rx_fill[0] = 8'd5; rx_err[0] = 1'b1;
    settle();
    do_upd();
    chk("R2", "receiver with error type", 32'(cir), 32'h05A);
  endtask

  task automatic t_tie();
    clear_inputs();
    mask = 18'h3; rx_fill[0] = 8'd5; rx_fill[1] = 8'd5;
    settle();
    do_upd();
    chk("R7", "equal bids pick channel B", 32'(cir), 32'h053);
    rx_fill[0] = 8'd6;
    settle();
    do_upd();
    chk("R7", "larger count beats channel", 32'(cir), 32'h062);
  endtask

  task automatic t_threshold();
    clear_inputs();
    mask = 18'h1; rx_fill[0] = 8'd5; thresh = 11'h29;
    settle();
    chk("R6", "equal to threshold no irq", 32'(irq_n), 32'h1);
    do_upd();
    chk("R9", "zero capture when below", 32'(cir), 32'h0);
    thresh = 11'h28;
    settle();
    chk("R6", "above threshold irq", 32'(irq_n), 32'h0);
    do_upd();
    chk("R6", "capture above threshold", 32'(cir), 32'h052);
    mask = 18'h2; rx_fill[1] = 8'd5; thresh = 11'h29;
    settle();
    chk("R6", "channel bit ignored by threshold", 32'(irq_n), 32'h1);
  endtask

  task automatic t_events();
    clear_inputs();
    prio[0] = 7'h7F; mask = 18'h1 << 6;
    pulse_evt(2);
    settle();
    chk("R10", "break status set", 32'(status_view[6]), 32'h1);
    do_upd();
    chk("R3", "break channel A bid", 32'(cir), 32'hFFC);
    stat_clr[2] = 1'b1;
    @(negedge clk);
    stat_clr[2] = 1'b0;
    settle();
    chk("R10", "break status cleared", 32'(status_view[6]), 32'h0);
    chk("R10", "cleared source stops bidding", 32'(irq_n), 32'h1);
    // counter 0 against pin change 1
    prio[10] = 7'h01; prio[9] = 7'h01; mask = (18'h1 << 16) | (18'h1 << 15);
    pulse_evt(12);
    pulse_evt(11);
    settle();
    do_upd();
    chk("R3", "counter beats pin change", 32'(cir), 32'h030);
    stat_clr[12] = 1'b1;
    @(negedge clk);
    stat_clr[12] = 1'b0;
    settle();
    do_upd();
    chk("R3", "pin change port 1 bid", 32'(cir), 32'h02D);
    // loopback B, flow A, address B
    clear_inputs();
    prio[3] = 7'h10; prio[4] = 7'h10; prio[7] = 7'h10;
    mask = (18'h1 << 9) | (18'h1 << 10) | (18'h1 << 13);
    pulse_evt(5);
    pulse_evt(6);
    pulse_evt(9);
    settle();
    do_upd();
    chk("R3", "loopback B bid", 32'(cir), 32'h21F);
    stat_clr[5] = 1'b1;
    @(negedge clk);
    stat_clr[5] = 1'b0;
    settle();
    do_upd();
    chk("R3", "address B bid", 32'(cir), 32'h217);
    stat_clr[9] = 1'b1;
    @(negedge clk);
    stat_clr[9] = 1'b0;
    settle();
    do_upd();
    chk("R3", "flow character A bid", 32'(cir), 32'h20E);
    // watchdog B with empty FIFO, zero threshold
    clear_inputs();
    mask = 18'h1 << 5; rx_fill[1] = 8'd0;
    pulse_evt(1);
    settle();
    chk("R12", "lowest bid still raises irq", 32'(irq_n), 32'h0);
    do_upd();
    chk("R3", "watchdog B bid", 32'(cir), 32'h009);
    rx_fill[1] = 8'd3;
    settle();
    do_upd();
    chk("R3", "watchdog B follows fill", 32'(cir), 32'h039);
  endtask

  task automatic t_set_clear();
    clear_inputs();
    evt_in[2] = 1'b1; stat_clr[2] = 1'b1;
    @(negedge clk);
    evt_in[2] = 1'b0; stat_clr[2] = 1'b0;
    @(negedge clk);
    chk("R10", "set and clear together from clear", 32'(status_view[6]), 32'h1);
    evt_in[2] = 1'b1; stat_clr[2] = 1'b1;
    @(negedge clk);
    evt_in[2] = 1'b0; stat_clr[2] = 1'b0;
    @(negedge clk);
    chk("R10", "set and clear together from set", 32'(status_view[6]), 32'h1);
    stat_clr[2] = 1'b1;
    @(negedge clk);
    stat_clr[2] = 1'b0;
    @(negedge clk);
    chk("R10", "clear alone", 32'(status_view[6]), 32'h0);
  endtask

  task automatic t_view();
    clear_inputs();
    prio[0] = 7'h05;
    pulse_evt(2);
    settle();
    chk("R11", "raw view shows unmasked bit", 32'(status_view), 32'h40);
    chk("R5", "unmasked event keeps irq_n high", 32'(irq_n), 32'h1);
    masked_view = 1'b1;
    @(negedge clk);
    chk("R11", "masked view hides bit", 32'(status_view), 32'h0);
    mask = 18'h1 << 6;
    @(negedge clk);
    chk("R11", "masked view with mask set", 32'(status_view), 32'h40);
  endtask

  task automatic t_hold();
    clear_inputs();
    mask = 18'h1; rx_fill[0] = 8'd5;
    settle();
    do_upd();
    chk("R9", "captured before hold", 32'(cir), 32'h052);
    rx_fill[0] = 8'd9; mask = 18'h0;
    settle();
    chk("R9", "cir holds without strobe", 32'(cir), 32'h052);
    do_ack();
    chk("R9", "ack loads zero when idle", 32'(cir), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rx_fill = '0; rx_err = '0; rx_lvl = '0; tx_free = '0; tx_lvl = '0;
    evt_in = '0; stat_clr = '0; prio = '0; mask = '0; thresh = '0;
    masked_view = 1'b0; ack_stb = 1'b0; upd_stb = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_rx_basic();
    t_mask();
    t_levels();
    t_rx_error();
    t_tie();
    t_threshold();
    t_events();
    t_set_clear();
    t_view();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule